// File: doc/BRIEF.md
# I2C EEPROM Command Controller

This block lets a host run single-location EEPROM accesses by writing two registers. It does not drive the I2C wires itself. It breaks each command into a short series of byte transactions and passes them to a lower-level I2C master byte engine over a request/acknowledge handshake. For each transaction the engine reports one of four outcomes: the transaction was accepted, the device did not acknowledge, arbitration was lost, or the bus was busy.

The host writes a command code and an EEPROM address into the command register. Setting the busy bit in that same write starts the operation. The host then polls until the busy bit clears. Three commands exist:

- A read fetches one byte into the data register.
- A write stores the byte that the host placed in the data register beforehand.
- A reload makes the configuration loader read locations 0 to RELOAD_BYTES-1 in order and present each byte on a loader port.

Two cycle counters guard every operation, and both report through one sticky timeout flag:

- An overall arbitration limit, counted from the start of the command.
- A device-response limit, counted from the first time the controller wins the bus.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After reset, both registers read as zero and no engine request is raised.
- R2: Command register layout: bit 31 is busy, bits 30:28 are the command, bit 8 is the timeout flag, and bits 7:0 are the address. The data register is bits 7:0 of the second register (`host_sel`=1). A write that sets bit 31 while idle starts the command. For a read (command 000), the engine sees START with byte {DEV_ADDR,0}, then WRITE of the address, then START with byte {DEV_ADDR,1}, then READ, then STOP. When busy clears, the data register holds the byte that was read.
- R3: For a write (command 011), the engine sees START {DEV_ADDR,0}, WRITE of the address, WRITE of the data byte that was preloaded, and STOP. Busy clears afterwards.
- R4: For a reload (command 111), the controller performs RELOAD_BYTES read sequences at addresses 0,1,2,… in order. Each byte is pulsed once on the loader port, together with its address. No data-write phase occurs.
- R5: Any other command code clears busy within three cycles, raises no engine request and leaves the timeout flag at 0.
- R6: While busy, host writes leave the running command and address unchanged, and data-register writes are ignored.
- R7: Engine status codes are 0 = accepted, 1 = no acknowledge, 2 = arbitration lost, and 3 = bus busy. After a lost or busy START, the controller retries START without issuing STOP. If arbitration is still not won once ARB_LIMIT cycles have passed since the start, the command ends without STOP and the timeout flag is set.
- R8: After a no-acknowledge, the controller issues STOP and then restarts the sequence. Once DEV_LIMIT cycles have passed since the first bus win, a no-acknowledge ends the command after STOP, with the timeout flag set.
- R9: The timeout flag stays set until the host writes 1 to bit 8. It is cleared when a new command starts.
- R10: The arbitration limit counts total time from the start. Winning an earlier phase does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 = command register, 1 = data register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected register contents |
| eng_req | output | 1 | Byte transaction request to the I2C engine |
| eng_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| eng_wbyte | output | 8 | Byte to send (control byte for START) |
| eng_ack | input | 1 | One-cycle completion of the current request |
| eng_status | input | 2 | Transaction outcome, valid with eng_ack |
| eng_rbyte | input | 8 | Byte received by a READ, valid with eng_ack |
| load_valid | output | 1 | One-cycle pulse for each byte that a reload fetches |
| load_addr | output | 8 | Address of the reloaded byte |
| load_data | output | 8 | Reloaded byte |

## Verification
The bench engine model runs read, write and reload commands against an engine that accepts everything at once. This shows that each command produces its own transaction order. The same commands are then run with arbitration lost a fixed number of times before a win, which separates retry-without-STOP from the abort path. A second pattern makes the engine lose every repeated START after an early win. Only a timer that is never restarted between phases ends that case near ARB_LIMIT. A third pattern refuses every acknowledge, which separates the STOP-then-retry loop from the device-limit abort. A busy-time write and an unknown command code show that the running state is held and that no bus traffic is created.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    CMD_READ   = 3'b000,
    CMD_WRITE  = 3'b011,
    CMD_RELOAD = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_NACK = 2'd1,
    ST_LOST = 2'd2,
    ST_BUSY = 2'd3
  } eng_st_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_WDATA, S_RSTART, S_RDATA, S_STOP, S_DONE
  } seq_state_e;

endpackage

// File: rtl/eeprom_tmo_counter.sv
module eeprom_tmo_counter #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic exp_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  assign exp_o = (cnt_q == LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)               cnt_d = '0;
    else if (en_i && !exp_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: once expired, the limit stays reached until a new command clears it
  a_r10_exp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    exp_o && !clr_i |=> exp_o);

endmodule

// File: rtl/eeprom_seq_fsm.sv
module eeprom_seq_fsm
  import eeprom_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'h50,
  parameter int         RELOAD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wbyte_i,
  input  logic              arb_exp_i,
  input  logic              dev_exp_i,
  output logic              active_o,
  output logic              won_o,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [7:0]        eng_wbyte_o,
  input  logic              eng_ack_i,
  input  logic [1:0]        eng_status_i,
  input  logic [7:0]        eng_rbyte_i,
  output logic              rd_we_o,
  output logic [7:0]        rd_byte_o,
  output logic              done_o,
  output logic              tmo_o,
  output logic              load_valid_o,
  output logic [ADDR_W-1:0] load_addr_o,
  output logic [7:0]        load_data_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(RELOAD_BYTES - 1);

  seq_state_e        state_q, state_d;
  logic [2:0]        op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        wb_q, wb_d;
  logic              retry_q, retry_d, abort_q, abort_d, won_q, won_d;
  logic              ldv_q, ldv_d;
  logic [ADDR_W-1:0] lda_q, lda_d;
  logic [7:0]        ldd_q, ldd_d;
  logic              cmd_ok;

  assign cmd_ok = (cmd_i == CMD_READ) || (cmd_i == CMD_WRITE) || (cmd_i == CMD_RELOAD);

  always_comb begin
    state_d = state_q; op_d = op_q; addr_d = addr_q; wb_d = wb_q;
    retry_d = retry_q; abort_d = abort_q; won_d = won_q;
    ldv_d = 1'b0; lda_d = lda_q; ldd_d = ldd_q;
    case (state_q)
      S_IDLE: if (start_i) begin
        op_d = cmd_i; wb_d = wbyte_i;
        addr_d = (cmd_i == CMD_RELOAD) ? '0 : addr_i;
        retry_d = 1'b0; abort_d = 1'b0; won_d = 1'b0;
        state_d = cmd_ok ? S_START : S_DONE;
      end
      S_START, S_RSTART: if (eng_ack_i) begin
        if (eng_status_i == ST_OK) begin
          won_d = 1'b1;
          state_d = (state_q == S_START) ? S_ADDR : S_RDATA;
        end else if (eng_status_i == ST_NACK) begin
          won_d = 1'b1; retry_d = 1'b1; abort_d = dev_exp_i;
          state_d = S_STOP;
        end else if (arb_exp_i) begin
          abort_d = 1'b1; state_d = S_DONE;
        end else begin
          state_d = S_START;
        end
      end
      S_ADDR, S_WDATA: if (eng_ack_i) begin
        if (eng_status_i == ST_OK) begin
          if (state_q == S_WDATA)    state_d = S_STOP;
          else if (op_q == CMD_WRITE) state_d = S_WDATA;
          else                        state_d = S_RSTART;
        end else begin
          retry_d = 1'b1; abort_d = dev_exp_i; state_d = S_STOP;
        end
      end
      S_RDATA: if (eng_ack_i) begin
        if (op_q == CMD_RELOAD) begin
          ldv_d = 1'b1; lda_d = addr_q; ldd_d = eng_rbyte_i;
        end
        state_d = S_STOP;
      end
      S_STOP: if (eng_ack_i) begin
        if (abort_q) state_d = S_DONE;
        else if (retry_q) begin
          retry_d = 1'b0; state_d = S_START;
        end else if (op_q == CMD_RELOAD && addr_q != LAST_ADDR) begin
          addr_d = addr_q + 1'b1; state_d = S_START;
        end else state_d = S_DONE;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; op_q <= '0; addr_q <= '0; wb_q <= '0;
      retry_q <= 1'b0; abort_q <= 1'b0; won_q <= 1'b0;
      ldv_q <= 1'b0; lda_q <= '0; ldd_q <= '0;
    end else begin
      state_q <= state_d; op_q <= op_d; addr_q <= addr_d; wb_q <= wb_d;
      retry_q <= retry_d; abort_q <= abort_d; won_q <= won_d;
      ldv_q <= ldv_d; lda_q <= lda_d; ldd_q <= ldd_d;
    end
  end

  always_comb begin
    eng_req_o = 1'b1; eng_op_o = OP_STOP; eng_wbyte_o = '0;
    case (state_q)
      S_START:  begin eng_op_o = OP_START; eng_wbyte_o = {DEV_ADDR, 1'b0}; end
      S_RSTART: begin eng_op_o = OP_START; eng_wbyte_o = {DEV_ADDR, 1'b1}; end
      S_ADDR:   begin eng_op_o = OP_WRITE; eng_wbyte_o = addr_q; end
      S_WDATA:  begin eng_op_o = OP_WRITE; eng_wbyte_o = wb_q; end
      S_RDATA:  eng_op_o = OP_READ;
      S_STOP:   eng_op_o = OP_STOP;
      default:  eng_req_o = 1'b0;
    endcase
  end

  assign active_o     = (state_q != S_IDLE);
  assign won_o        = won_q;
  assign rd_we_o      = (state_q == S_RDATA) && eng_ack_i && (op_q == CMD_READ);
  assign rd_byte_o    = eng_rbyte_i;
  assign done_o       = (state_q == S_DONE);
  assign tmo_o        = (state_q == S_DONE) && abort_q;
  assign load_valid_o = ldv_q;
  assign load_addr_o  = lda_q;
  assign load_data_o  = ldd_q;

  // R8: a refused acknowledge while owning the bus is followed by STOP
  a_r8_stop_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ack_i && eng_status_i == ST_NACK &&
    (state_q == S_START || state_q == S_ADDR || state_q == S_WDATA)
    |=> eng_req_o && eng_op_o == OP_STOP);

  // R7: lost arbitration before the limit retries START with no STOP
  a_r7_retry_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ack_i && state_q == S_START && eng_status_i == ST_LOST && !arb_exp_i
    |=> eng_req_o && eng_op_o == OP_START);

  // R5: an unknown command code never reaches the engine
  a_r5_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_IDLE && start_i && !cmd_ok |=> !eng_req_o);

  // R4: a reload never enters the data-write phase
  a_r4_reload_reads: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && op_q == CMD_RELOAD |-> state_q != S_WDATA);

endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
  import eeprom_cmd_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR     = 7'h50,
  parameter int          RELOAD_BYTES = 4,
  parameter int unsigned ARB_LIMIT    = 480_000_000,
  parameter int unsigned DEV_LIMIT    = 7_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic        host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        eng_req,
  output logic [1:0]  eng_op,
  output logic [7:0]  eng_wbyte,
  input  logic        eng_ack,
  input  logic [1:0]  eng_status,
  input  logic [7:0]  eng_rbyte,
  output logic        load_valid,
  output logic [7:0]  load_addr,
  output logic [7:0]  load_data
);
  localparam int BUSY_B = 31;
  localparam int TMO_B  = 8;

  logic [1:0] rsync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  logic              busy_q, busy_d, tmo_q, tmo_d;
  logic [2:0]        cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic              cmd_wr, start_c;
  logic              done_w, tmo_w, rd_we_w, active_w, won_w, arb_exp, dev_exp;
  logic [7:0]        rd_byte_w;
  logic              unused_wbits;

  assign unused_wbits = ^host_wdata[27:9];
  assign cmd_wr  = host_we && !host_sel && !busy_q;
  assign start_c = cmd_wr && host_wdata[BUSY_B];

  always_comb begin
    busy_d = busy_q; cmd_d = cmd_q; addr_d = addr_q; tmo_d = tmo_q; data_d = data_q;
    if (start_c)     busy_d = 1'b1;
    else if (done_w) busy_d = 1'b0;
    if (cmd_wr) begin
      cmd_d  = host_wdata[30:28];
      addr_d = host_wdata[ADDR_W-1:0];
    end
    if (start_c)     tmo_d = 1'b0;
    else if (tmo_w)  tmo_d = 1'b1;
    else if (host_we && !host_sel && host_wdata[TMO_B]) tmo_d = 1'b0;
    if (rd_we_w)     data_d = rd_byte_w;
    else if (host_we && host_sel && !busy_q) data_d = host_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0; cmd_q <= '0; addr_q <= '0; tmo_q <= 1'b0; data_q <= '0;
    end else begin
      busy_q <= busy_d; cmd_q <= cmd_d; addr_q <= addr_d; tmo_q <= tmo_d; data_q <= data_d;
    end
  end

  assign host_rdata = host_sel ? {24'b0, data_q}
                               : {busy_q, cmd_q, 19'b0, tmo_q, addr_q};

  eeprom_tmo_counter #(.LIMIT(ARB_LIMIT)) u_arb_tmr (
    .clk(clk), .rst_n(rst_n_s), .clr_i(start_c), .en_i(active_w), .exp_o(arb_exp));

  eeprom_tmo_counter #(.LIMIT(DEV_LIMIT)) u_dev_tmr (
    .clk(clk), .rst_n(rst_n_s), .clr_i(start_c), .en_i(won_w), .exp_o(dev_exp));

  eeprom_seq_fsm #(.DEV_ADDR(DEV_ADDR), .RELOAD_BYTES(RELOAD_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .start_i(start_c), .cmd_i(host_wdata[30:28]), .addr_i(host_wdata[ADDR_W-1:0]),
    .wbyte_i(data_q), .arb_exp_i(arb_exp), .dev_exp_i(dev_exp),
    .active_o(active_w), .won_o(won_w),
    .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_wbyte_o(eng_wbyte),
    .eng_ack_i(eng_ack), .eng_status_i(eng_status), .eng_rbyte_i(eng_rbyte),
    .rd_we_o(rd_we_w), .rd_byte_o(rd_byte_w), .done_o(done_w), .tmo_o(tmo_w),
    .load_valid_o(load_valid), .load_addr_o(load_addr), .load_data_o(load_data));

  // R2: completion of the sequence drops the busy bit
  a_r2_busy_drop: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_w |=> !busy_q);

  // R6: command and address stay fixed for as long as busy holds
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy_q && $past(busy_q) |-> $stable(cmd_q) && $stable(addr_q));

  // R9: starting a command clears the timeout flag
  a_r9_tmo_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_c |=> !tmo_q);

endmodule

// File: tb/eeprom_cmd_ctrl_tb_top.sv
module eeprom_cmd_ctrl_tb_top;
  import eeprom_cmd_pkg::*;

  localparam int ARB = 300;
  localparam int DEV = 80;
  localparam int NRL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0, host_sel = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic eng_req, eng_ack;
  logic [1:0] eng_op, eng_status;
  logic [7:0] eng_wbyte, eng_rbyte;
  logic load_valid;
  logic [7:0] load_addr, load_data;

  always #2 clk = ~clk;

  eeprom_cmd_ctrl #(.DEV_ADDR(7'h50), .RELOAD_BYTES(NRL), .ARB_LIMIT(ARB), .DEV_LIMIT(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
    .eng_ack(eng_ack), .eng_status(eng_status), .eng_rbyte(eng_rbyte),
    .load_valid(load_valid), .load_addr(load_addr), .load_data(load_data));

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [1:0] lg_op [256];
  logic [7:0] lg_b  [256];
  int lg_n = 0;
  logic [7:0] ld_a [16];
  logic [7:0] ld_d [16];
  int ld_n = 0;
  int lose_n = 0, start_cnt = 0;
  bit nack_all = 1'b0, rstart_lose = 1'b0;
  logic [7:0] cur_addr = '0;
  logic [1:0] prev_op = OP_STOP;
  logic [7:0] prev_b = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // engine model
  initial begin
    eng_ack = 1'b0; eng_status = ST_OK; eng_rbyte = '0;
    forever begin
      @(negedge clk);
      if (eng_req && rst_n) begin
        logic [1:0] st;
        st = ST_OK;
        if (lg_n < 256) begin lg_op[lg_n] = eng_op; lg_b[lg_n] = eng_wbyte; lg_n++; end
        if (eng_op == OP_START && !eng_wbyte[0]) begin
          start_cnt++;
          if (start_cnt <= lose_n) st = start_cnt[0] ? ST_LOST : ST_BUSY;
          else if (nack_all) st = ST_NACK;
        end else if (eng_op == OP_START) begin
          if (rstart_lose) st = ST_LOST;
        end else if (eng_op == OP_WRITE && prev_op == OP_START && !prev_b[0]) begin
          cur_addr = eng_wbyte;
        end
        prev_op = eng_op; prev_b = eng_wbyte;
        repeat (2) @(negedge clk);
        eng_ack = 1'b1; eng_status = st; eng_rbyte = cur_addr ^ 8'h5A;
        @(negedge clk);
        eng_ack = 1'b0;
      end
    end
  end

  always @(negedge clk) if (load_valid && ld_n < 16) begin
    ld_a[ld_n] = load_addr; ld_d[ld_n] = load_data; ld_n++;
  end

  task automatic host_wr(input bit sel, input logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk); host_we = 1'b0; host_sel = 1'b0;
  endtask

  task automatic host_rd(input bit sel, output logic [31:0] d);
    @(negedge clk); host_sel = sel; #0.1 d = host_rdata; host_sel = 1'b0;
  endtask

  task automatic clear_env();
    lg_n = 0; ld_n = 0; start_cnt = 0; lose_n = 0; nack_all = 0; rstart_lose = 0;
    prev_op = OP_STOP;
  endtask

  function automatic logic [31:0] cmd_word(input bit go, input logic [2:0] c,
                                          input bit w1c, input logic [7:0] a);
    return {go, c, 19'b0, w1c, a};
  endfunction

  // start a command, return cycles until busy reads 0
  task automatic run_cmd(input logic [31:0] w, output int cyc);
    logic [31:0] r;
    host_wr(1'b0, w);
    cyc = 1;
    r = host_rdata;
    while (r[31] && cyc < 5000) begin
      @(negedge clk); cyc++; r = host_rdata;
    end
  endtask

  task automatic t_reset();
    logic [31:0] r;
    host_rd(1'b0, r); chk(r == 0, "R1", "command register after reset", r, 0);
    host_rd(1'b1, r); chk(r == 0, "R1", "data register after reset", r, 0);
    chk(eng_req == 1'b0, "R1", "engine request after reset", eng_req, 0);
  endtask

  task automatic t_read();
    int c; logic [31:0] r;
    clear_env();
    run_cmd(cmd_word(1, CMD_READ, 0, 8'h3C), c);
    chk(lg_n == 5, "R2", "read transaction count", lg_n, 5);
    chk(lg_op[0] == OP_START && lg_b[0] == 8'hA0, "R2", "first START", {lg_op[0], lg_b[0]}, {2'd0, 8'hA0});
    chk(lg_op[1] == OP_WRITE && lg_b[1] == 8'h3C, "R2", "address byte", {lg_op[1], lg_b[1]}, {2'd1, 8'h3C});
    chk(lg_op[2] == OP_START && lg_b[2] == 8'hA1, "R2", "repeated START", {lg_op[2], lg_b[2]}, {2'd0, 8'hA1});
    chk(lg_op[3] == OP_READ && lg_op[4] == OP_STOP, "R2", "READ then STOP", {lg_op[3], lg_op[4]}, {2'd2, 2'd3});
    host_rd(1'b1, r); chk(r == 32'h66, "R2", "read byte in data register", r, 32'h66);
    host_rd(1'b0, r); chk(r == cmd_word(0, CMD_READ, 0, 8'h3C), "R2", "command register after read", r, cmd_word(0, CMD_READ, 0, 8'h3C));
  endtask

  task automatic t_write();
    int c; logic [31:0] r;
    clear_env();
    host_wr(1'b1, 32'hC3);
    run_cmd(cmd_word(1, CMD_WRITE, 0, 8'h11), c);
    chk(lg_n == 4, "R3", "write transaction count", lg_n, 4);
    chk(lg_op[1] == OP_WRITE && lg_b[1] == 8'h11, "R3", "address byte", lg_b[1], 8'h11);
    chk(lg_op[2] == OP_WRITE && lg_b[2] == 8'hC3, "R3", "data byte", lg_b[2], 8'hC3);
    chk(lg_op[3] == OP_STOP, "R3", "final STOP", lg_op[3], OP_STOP);
    host_rd(1'b0, r); chk(r[31] == 1'b0, "R3", "busy cleared", r[31], 0);
  endtask

  task automatic t_reload();
    int c, nw, nr;
    clear_env();
    run_cmd(cmd_word(1, CMD_RELOAD, 0, 8'h00), c);
    nw = 0; nr = 0;
    for (int i = 0; i < lg_n; i++) begin
      if (lg_op[i] == OP_WRITE) nw++;
      if (lg_op[i] == OP_READ) nr++;
    end
    chk(lg_n == 5 * NRL, "R4", "reload transaction count", lg_n, 5 * NRL);
    chk(nw == NRL && nr == NRL, "R4", "only address writes and reads", {nw[15:0], nr[15:0]}, {16'(NRL), 16'(NRL)});
    chk(ld_n == NRL, "R4", "loader pulses", ld_n, NRL);
    for (int i = 0; i < NRL; i++) begin
      chk(ld_a[i] == 8'(i) && ld_d[i] == (8'(i) ^ 8'h5A), "R4", "loader byte in order",
          {ld_a[i], ld_d[i]}, {8'(i), 8'(i) ^ 8'h5A});
    end
  endtask

  task automatic t_badcmd();
    int c; logic [31:0] r;
    clear_env();
    run_cmd(cmd_word(1, 3'b010, 0, 8'h05), c);
    chk(c <= 3, "R5", "unknown command completion cycles", c, 3);
    repeat (4) @(negedge clk);
    chk(lg_n == 0, "R5", "no engine requests", lg_n, 0);
    host_rd(1'b0, r); chk(r[8] == 1'b0, "R5", "timeout flag stays clear", r[8], 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] r;
    clear_env();
    lose_n = 20;
    host_wr(1'b1, 32'h44);
    host_wr(1'b0, cmd_word(1, CMD_WRITE, 0, 8'h20));
    repeat (5) @(negedge clk);
    host_wr(1'b0, cmd_word(1, CMD_READ, 0, 8'h77));
    host_wr(1'b1, 32'h99);
    host_rd(1'b0, r); chk(r == cmd_word(1, CMD_WRITE, 0, 8'h20), "R6", "command held during busy", r, cmd_word(1, CMD_WRITE, 0, 8'h20));
    r = host_rdata;
    while (r[31]) begin @(negedge clk); r = host_rdata; end
    chk(lg_b[lg_n-2] == 8'h44, "R6", "written data byte unchanged", lg_b[lg_n-2], 8'h44);
    chk(lg_b[lg_n-3] == 8'h20, "R6", "address unchanged", lg_b[lg_n-3], 8'h20);
    host_rd(1'b1, r); chk(r == 32'h44, "R6", "data register unchanged", r, 32'h44);
  endtask

  task automatic t_arb_tmo();
    int c, nstop; logic [31:0] r;
    clear_env();
    lose_n = 1000000;
    run_cmd(cmd_word(1, CMD_READ, 0, 8'h01), c);
    nstop = 0;
    for (int i = 0; i < lg_n; i++) if (lg_op[i] != OP_START) nstop++;
    chk(nstop == 0, "R7", "only START retries, no STOP", nstop, 0);
    chk(lg_n > 10, "R7", "START retried", lg_n, 11);
    chk(c >= ARB && c <= ARB + 20, "R7", "abort time", c, ARB);
    host_rd(1'b0, r); chk(r[8] == 1'b1, "R7", "timeout flag set", r[8], 1);
  endtask

  task automatic t_arb_total();
    int c, nw; logic [31:0] r;
    clear_env();
    lose_n = 40; rstart_lose = 1'b1;
    run_cmd(cmd_word(1, CMD_READ, 0, 8'h02), c);
    nw = 0;
    for (int i = 0; i < lg_n; i++) if (lg_op[i] == OP_WRITE) nw++;
    chk(nw > 0, "R10", "address phase reached before abort", nw, 1);
    chk(c >= ARB && c <= ARB + 20, "R10", "limit counted from start", c, ARB);
    host_rd(1'b0, r); chk(r[8] == 1'b1, "R10", "timeout flag set", r[8], 1);
  endtask

  task automatic t_dev_tmo();
    int c; bit alt; logic [31:0] r;
    clear_env();
    nack_all = 1'b1;
    run_cmd(cmd_word(1, CMD_WRITE, 0, 8'h03), c);
    alt = 1'b1;
    for (int i = 0; i < lg_n; i++)
      if (lg_op[i] != ((i % 2 == 0) ? OP_START : OP_STOP)) alt = 1'b0;
    chk(alt && lg_n > 4, "R8", "START/STOP alternation", lg_n, 0);
    chk(lg_op[lg_n-1] == OP_STOP, "R8", "last transaction STOP", lg_op[lg_n-1], OP_STOP);
    chk(c >= DEV && c < ARB, "R8", "device limit abort time", c, DEV);
    host_rd(1'b0, r); chk(r[8] == 1'b1, "R8", "timeout flag set", r[8], 1);
  endtask

  task automatic t_sticky();
    int c; logic [31:0] r;
    host_wr(1'b0, cmd_word(0, CMD_READ, 0, 8'h00));
    host_rd(1'b0, r); chk(r[8] == 1'b1, "R9", "flag survives write of 0", r[8], 1);
    host_wr(1'b0, cmd_word(0, CMD_READ, 1, 8'h00));
    host_rd(1'b0, r); chk(r[8] == 1'b0, "R9", "write 1 clears flag", r[8], 0);
    t_dev_tmo();
    clear_env();
    lose_n = 10;
    host_wr(1'b0, cmd_word(1, CMD_READ, 0, 8'h04));
    host_rd(1'b0, r); chk(r[31] && !r[8], "R9", "new start clears flag", r[8], 0);
    r = host_rdata;
    while (r[31]) begin @(negedge clk); r = host_rdata; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_reload();
    t_badcmd();
    t_busy_ignore();
    t_arb_tmo();
    t_arb_total();
    t_dev_tmo();
    t_sticky();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule